// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a sum-of-products programmable array. It receives one finished sum term from the array and a per-cell output-enable product term. It also takes two shared control terms: a clear that acts without a clock and a preset that acts on the clock. The cell drives a tri-state pad model made of a data line, an enable line and an external pin level, and returns a feedback literal, with its complement, to the array.

Two static configuration bits shape the cell. The mode bit chooses between a clocked path, where a D flip-flop drives the pad, and a direct path, where the sum term drives the pad. The polarity bit chooses whether the pad carries the internal value or its inverse. The mode also picks the feedback source. In the clocked path the register state is fed back, so the pad can only act as an output. In the direct path the resolved pin level is fed back, so the pad can act as an input whenever its driver is off. A test preload port can force the register to any value, including states the logic would never reach.

Top module: `pld_out_macrocell`

## Requirements
- R1: While rst_ni is low the register holds 0. With cfg_comb_i=0 the pad then reads 0 when cfg_pol_i=1 and 1 when cfg_pol_i=0.
- R2: With cfg_comb_i=0 the register captures sum_i on each rising clk_i edge when no clear, preload or preset is active. pad_o equals the register when cfg_pol_i=1 and its inverse when cfg_pol_i=0.
- R3: With cfg_comb_i=0, fb_o equals the register value and fb_n_o its inverse, whatever pin_i carries.
- R4: With cfg_comb_i=1, pad_o follows sum_i in the same cycle, true when cfg_pol_i=1 and inverted when cfg_pol_i=0.
- R5: With cfg_comb_i=1, fb_o equals the resolved pin level and fb_n_o its inverse. The resolved level is pad_o when pad_oe_o=1 and pin_i when pad_oe_o=0.
- R6: pad_oe_o follows oe_term_i in both modes. Holding it at 1 makes a fixed output, holding it at 0 makes a fixed input, and toggling it gives a bidirectional pin.
- R7: areset_i=1 clears the register to 0 at once, without a clock edge, and holds it at 0 while asserted. It overrides preload, preset and sum_i.
- R8: spreset_i=1 with no preload sets the register to 1 at the next rising edge, overriding sum_i.
- R9: pl_en_i=1 loads pl_val_i into the register at the next rising edge, overriding spreset_i and sum_i.
- R10: Clear and preset act on the register state and not on the pad. After a preset the pad reads 1 when cfg_pol_i=1 and 0 when cfg_pol_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| cfg_comb_i | input | 1 | Mode: 0 clocked, 1 direct |
| cfg_pol_i | input | 1 | Polarity: 1 true at pad, 0 inverted |
| sum_i | input | 1 | Sum term from the array |
| oe_term_i | input | 1 | Output-enable product term |
| areset_i | input | 1 | Shared clear term, acts without a clock |
| spreset_i | input | 1 | Shared preset term, acts on the clock edge |
| pl_en_i | input | 1 | Test preload request |
| pl_val_i | input | 1 | Test preload value |
| pin_i | input | 1 | External level on the pin when not driven |
| pad_o | output | 1 | Pad data |
| pad_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback literal, true polarity |
| fb_n_o | output | 1 | Feedback literal, complement |

## Verification
The assertions check the register's next-state rules on every cycle: capture, preset, preload and the hold at 0 during a clear. They also check, on every cycle, that the feedback matches the pad level in clocked mode and the external pin in direct mode when the driver is off. Only the bench scenarios can show the priority order among several terms asserted in the same cycle, a clear that arrives between clock edges and takes effect before the next edge, and the pad level produced by preset and reset under each polarity. The reference model compares every output each cycle while the bench walks through both modes, both polarities and fully random term patterns.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_COMB = 1'b1
  } mc_mode_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } mc_pol_e;

  localparam logic Q_POR = 1'b0;
  localparam logic Q_SET = 1'b1;
endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import pld_mc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic preset_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  input  logic d_i,
  output logic q_o
);
  logic clr_n;
  assign clr_n = rst_ni & ~clr_i;

  // clear > preload > preset > data
  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n)        q_o <= Q_POR;
    else if (pl_en_i)  q_o <= pl_val_i;
    else if (preset_i) q_o <= Q_SET;
    else               q_o <= d_i;
  end

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!pl_en_i && !preset_i) |=> (q_o == $past(d_i)));
  a_r8_preset: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (preset_i && !pl_en_i) |=> (q_o == 1'b1));
  a_r9_preload: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    pl_en_i |=> (q_o == $past(pl_val_i)));
  a_r7_clear_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (q_o == 1'b0));
endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage
  import pld_mc_pkg::*;
(
  input  mc_mode_e mode_i,
  input  mc_pol_e  pol_i,
  input  logic     sum_i,
  input  logic     q_i,
  input  logic     oe_term_i,
  output logic     pad_o,
  output logic     pad_oe_o
);
  logic core;
  assign core     = (mode_i == MODE_COMB) ? sum_i : q_i;
  assign pad_o    = (pol_i == POL_HIGH) ? core : ~core;
  assign pad_oe_o = oe_term_i;
endmodule

// File: rtl/mc_fb_sel.sv
module mc_fb_sel
  import pld_mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mc_mode_e mode_i,
  input  logic     q_i,
  input  logic     pad_i,
  input  logic     pad_oe_i,
  input  logic     pin_i,
  output logic     fb_o,
  output logic     fb_n_o
);
  logic pin_lvl;
  assign pin_lvl = pad_oe_i ? pad_i : pin_i;
  // clocked mode returns register state, direct mode returns the pin
  assign fb_o   = (mode_i == MODE_COMB) ? pin_lvl : q_i;
  assign fb_n_o = ~fb_o;

  a_r5_fb_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_COMB && !pad_oe_i) |-> (fb_o == pin_i));
endmodule

// File: rtl/pld_out_macrocell.sv
module pld_out_macrocell
  import pld_mc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_comb_i,
  input  logic cfg_pol_i,
  input  logic sum_i,
  input  logic oe_term_i,
  input  logic areset_i,
  input  logic spreset_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  input  logic pin_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic fb_o,
  output logic fb_n_o
);
  mc_mode_e mode;
  mc_pol_e  pol;
  logic     q;

  assign mode = mc_mode_e'(cfg_comb_i);
  assign pol  = mc_pol_e'(cfg_pol_i);

  mc_state_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (areset_i),
    .preset_i (spreset_i),
    .pl_en_i  (pl_en_i),
    .pl_val_i (pl_val_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  mc_out_stage u_out (
    .mode_i    (mode),
    .pol_i     (pol),
    .sum_i     (sum_i),
    .q_i       (q),
    .oe_term_i (oe_term_i),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o)
  );

  mc_fb_sel u_fb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .q_i      (q),
    .pad_i    (pad_o),
    .pad_oe_i (pad_oe_o),
    .pin_i    (pin_i),
    .fb_o     (fb_o),
    .fb_n_o   (fb_n_o)
  );

  // registered feedback must agree with the pad through the polarity stage
  a_r3_fb_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_comb_i |-> (fb_o == (cfg_pol_i ? pad_o : ~pad_o)));
  a_r10_clear_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (areset_i && !cfg_comb_i) |-> (pad_o == ~cfg_pol_i));
endmodule

// File: tb/tb_pld_out_macrocell.sv
`timescale 1ns/1ps
module tb_pld_out_macrocell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comb = 1'b0, pol = 1'b1, sum = 1'b0, oe = 1'b1;
  logic ar = 1'b0, sp = 1'b0, ple = 1'b0, plv = 1'b0, pin = 1'b0;
  logic pad, pad_oe, fb, fb_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  logic mq = 1'b0;

  always #2 clk = ~clk;

  pld_out_macrocell dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_comb_i(comb), .cfg_pol_i(pol),
    .sum_i(sum), .oe_term_i(oe), .areset_i(ar), .spreset_i(sp),
    .pl_en_i(ple), .pl_val_i(plv), .pin_i(pin),
    .pad_o(pad), .pad_oe_o(pad_oe), .fb_o(fb), .fb_n_o(fb_n)
  );

  // behavioural reference register
  always @(posedge clk or posedge ar or negedge rst_n) begin
    if (!rst_n || ar) mq <= 1'b0;
    else if (ple)     mq <= plv;
    else if (sp)      mq <= 1'b1;
    else              mq <= sum;
  end

  function automatic logic exp_q();
    return (!rst_n || ar) ? 1'b0 : mq;
  endfunction
  function automatic logic exp_pad();
    logic c;
    c = comb ? sum : exp_q();
    return pol ? c : ~c;
  endfunction
  function automatic logic exp_fb();
    logic lvl;
    lvl = oe ? exp_pad() : pin;
    return comb ? lvl : exp_q();
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      chk(comb ? "R4" : "R2", pad, exp_pad());
      chk("R6", pad_oe, oe);
      chk(comb ? "R5" : "R3", fb, exp_fb());
      chk(comb ? "R5" : "R3", fb_n, ~exp_fb());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    // R1 reset state under both polarities
    cyc(2); #1;
    chk("R1", pad, 1'b0);
    pol = 1'b0; #0.5;
    chk("R1", pad, 1'b1);
    pol = 1'b1;
    cyc(1); rst_n = 1'b1; cmp_on = 1'b1;

    // R2 clocked capture, both polarities
    sum = 1'b1; cyc(1); #1.5; chk("R2", pad, 1'b1);
    pol = 1'b0; #0.2; chk("R2", pad, 1'b0);
    sum = 1'b0; cyc(1); #1.5; chk("R2", pad, 1'b1);

    // R3 feedback ignores pin in clocked mode
    oe = 1'b0; pin = 1'b1; #0.2; chk("R3", fb, 1'b0);
    pin = 1'b0; oe = 1'b1; pol = 1'b1;

    // R8 preset overrides sum, R10 pad under each polarity
    cyc(1); sp = 1'b1; sum = 1'b0;
    cyc(1); sp = 1'b0; #1.5; chk("R8", pad, 1'b1);
    pol = 1'b0; #0.2; chk("R10", pad, 1'b0);
    pol = 1'b1;

    // R9 preload 0 beats preset and sum
    cyc(1); ple = 1'b1; plv = 1'b0; sp = 1'b1; sum = 1'b1;
    cyc(1); ple = 1'b0; sp = 1'b0; sum = 1'b1; #1.5; chk("R9", pad, 1'b0);
    cyc(1); ple = 1'b1; plv = 1'b1; sum = 1'b0;
    cyc(1); ple = 1'b0; #1.5; chk("R9", fb, 1'b1);

    // R7 clear mid-cycle, no edge, then held against preload and preset
    #0.2; ar = 1'b1; #0.3; chk("R7", pad, 1'b0);
    chk("R7", fb, 1'b0);
    ple = 1'b1; plv = 1'b1; sp = 1'b1; sum = 1'b1;
    cyc(1); #1.5; chk("R7", pad, 1'b0);
    pol = 1'b0; #0.2; chk("R10", pad, 1'b1);
    cyc(1); ar = 1'b0; ple = 1'b0; sp = 1'b0; sum = 1'b0; pol = 1'b1;

    // R4 direct mode follows sum combinationally
    comb = 1'b1; sum = 1'b1; #0.5; chk("R4", pad, 1'b1);
    pol = 1'b0; #0.2; chk("R4", pad, 1'b0);
    // R5 pin feedback when driver off, R6 enable follows term
    oe = 1'b0; pin = 1'b1; #0.2; chk("R6", pad_oe, 1'b0);
    chk("R5", fb, 1'b1); chk("R5", fb_n, 1'b0);
    pin = 1'b0; #0.2; chk("R5", fb, 1'b0);
    oe = 1'b1; pin = 1'b1; #0.2; chk("R5", fb, 1'b0);
    cyc(2);

    // random sweep, inputs change only at falling edges
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i % 100 == 0) begin comb = $urandom_range(0, 1); pol = $urandom_range(0, 1); end
      sum = $urandom_range(0, 1);
      oe  = $urandom_range(0, 1);
      pin = $urandom_range(0, 1);
      sp  = ($urandom_range(0, 5) == 0);
      ple = ($urandom_range(0, 6) == 0);
      plv = $urandom_range(0, 1);
      ar  = ($urandom_range(0, 11) == 0);
    end
    cyc(2);
    finish_run();
  end
endmodule